// File: doc/BRIEF.md
# Polyphase Sample Repacker with Mirrored Queues

This block is the front end for a super-sample-rate filter array. Each clock it takes eight parallel 32-bit samples from a fast converter interface. Branch `b` of input vector `n` holds sample `8n+b`. The block regroups them into four 64-bit phase words. Each word holds two consecutive samples of one polyphase phase.

Every phase word is pushed into two queues that always hold the same data. One queue feeds the even processing rows and the other feeds the odd rows. Those rows start consuming at different offsets, typically 0 to 3 times a base latency of about 25 cycles. Each of the eight queues therefore has its own valid/ready read port, and it drains entirely on its own.

A queue pair accepts a word only when both of its members have room. If either member is full, both skip the word and a sticky overflow flag is raised for that pair. This keeps the two copies identical.

Top module: `ssr_phase_repacker`

## Requirements
- R1: After reset every queue reports empty and not full, every `out_valid` bit is low and every `overflow` bit is low.
- R2: Phase word `k` (k = 0..3) carries input branch `k` in bits 31:0 and branch `k+4` in bits 63:32. Branch `b` occupies bits `32b+31:32b` of `in_data`.
- R3: A vector accepted at clock edge `t` is not yet visible after edge `t`. It becomes readable (`out_valid` high) after edge `t+1`.
- R4: Consumer index `c = 2k+s` reads phase `k`, with `s=0` for the even copy and `s=1` for the odd copy. Both copies of a phase return the same words in arrival order, and its data sits at bits `64c+63:64c` of `out_data`.
- R5: Each consumer pops only on its own `out_valid && out_ready`. The timing of one consumer never changes what another consumer reads.
- R6: Cycles with `in_valid` low write nothing, whatever `in_data` holds.
- R7: A queue raises `fifo_full` when it holds `FIFO_DEPTH` words. It raises `fifo_empty` when it holds none.
- R8: If `in_valid` reaches a pair while either member is full (judged before that cycle's pops), neither member stores the word and that pair's `overflow` bit is set. Other pairs are unaffected.
- R9: An `overflow` bit stays high until reset, even after the queues drain and accept new words.
- R10: While `out_valid` is high and `out_ready` is low, that consumer's `out_valid` stays high and its `out_data` stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector valid |
| in_data | input | 256 | Eight 32-bit branches, branch b at bits 32b+31:32b |
| out_ready | input | 8 | Per-consumer ready, consumer c = 2k+s |
| out_valid | output | 8 | Per-consumer data valid |
| out_data | output | 512 | Per-consumer 64-bit phase word, consumer c at bits 64c+63:64c |
| fifo_full | output | 8 | Per-queue full flag |
| fifo_empty | output | 8 | Per-queue empty flag |
| overflow | output | 4 | Per-pair sticky overflow flag |

## Verification
The bench builds the block with the default sample width and branch count, and with `FIFO_DEPTH` lowered to 16. This lets a short run fill every queue and reach the full and overflow corners. The bench empties one member of a pair by a single word and then sends one more vector. This exposes whether the pair skips the write together and whether only the affected pairs flag overflow. The eight consumers are started at staggered offsets with differing ready patterns, so each copy is drained on a different schedule while its word order is checked.

// File: rtl/ssr_repack_pkg.sv
package ssr_repack_pkg;
  localparam int unsigned COPIES = 2;
  typedef enum logic {COPY_EVEN = 1'b0, COPY_ODD = 1'b1} copy_sel_e;
endpackage

// File: rtl/phase_packer.sv
module phase_packer #(
  parameter int unsigned SAMPLE_W = 32,
  parameter int unsigned N_BRANCH = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [N_BRANCH*SAMPLE_W-1:0]      in_data,
  output logic                              pk_valid,
  output logic [N_BRANCH*SAMPLE_W-1:0]      pk_words
);
  localparam int unsigned N_PHASE = N_BRANCH / 2;
  localparam int unsigned WORD_W  = 2 * SAMPLE_W;

  logic                         valid_d, valid_q;
  logic [N_BRANCH*SAMPLE_W-1:0] words_d, words_q, regrouped;

  // phase k: branch k low half, branch k+N_PHASE high half
  for (genvar k = 0; k < N_PHASE; k++) begin : g_phase
    assign regrouped[k*WORD_W +: SAMPLE_W] =
      in_data[k*SAMPLE_W +: SAMPLE_W];
    assign regrouped[k*WORD_W + SAMPLE_W +: SAMPLE_W] =
      in_data[(k+N_PHASE)*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    valid_d = in_valid;
    words_d = words_q;
    if (in_valid) words_d = regrouped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      words_q <= '0;
    end else begin
      valid_q <= valid_d;
      words_q <= words_d;
    end
  end

  assign pk_valid = valid_q;
  assign pk_words = words_q;
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr_d, rd_ptr_q, wr_ptr_d, wr_ptr_q;
  logic [CW-1:0]    cnt_d, cnt_q;
  logic             pop;

  assign pop = rd_valid && rd_ready;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (pop)   rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    if (wr_en) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    case ({wr_en, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  assign full     = (cnt_q == FULL_CNT);
  assign empty    = (cnt_q == '0);
  assign rd_valid = !empty;
  assign rd_data  = mem[rd_ptr_q];

  p_write_never_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  p_full_empty_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/mirrored_fifo_pair.sv
module mirrored_fifo_pair
  import ssr_repack_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pk_valid,
  input  logic [WIDTH-1:0]        pk_word,
  input  logic [COPIES-1:0]       rd_ready,
  output logic [COPIES-1:0]       rd_valid,
  output logic [COPIES*WIDTH-1:0] rd_data,
  output logic [COPIES-1:0]       full,
  output logic [COPIES-1:0]       empty,
  output logic                    overflow
);
  logic pair_we, blocked;
  logic ovf_d, ovf_q;

  assign blocked = |full;
  assign pair_we = pk_valid && !blocked;

  always_comb begin
    ovf_d = ovf_q;
    if (pk_valid && blocked) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign overflow = ovf_q;

  for (genvar s = 0; s < COPIES; s++) begin : g_copy
    word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pair_we),
      .wr_data (pk_word),
      .rd_ready(rd_ready[s]),
      .rd_valid(rd_valid[s]),
      .rd_data (rd_data[s*WIDTH +: WIDTH]),
      .full    (full[s]),
      .empty   (empty[s])
    );
  end

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_overflow_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(pk_valid && (full[COPY_EVEN] || full[COPY_ODD])));
endmodule

// File: rtl/ssr_phase_repacker.sv
module ssr_phase_repacker
  import ssr_repack_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 32,
  parameter int unsigned N_BRANCH   = 8,
  parameter int unsigned FIFO_DEPTH = 128
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       in_valid,
  input  logic [N_BRANCH*SAMPLE_W-1:0]               in_data,
  input  logic [N_BRANCH-1:0]                        out_ready,
  output logic [N_BRANCH-1:0]                        out_valid,
  output logic [N_BRANCH*2*SAMPLE_W-1:0]             out_data,
  output logic [N_BRANCH-1:0]                        fifo_full,
  output logic [N_BRANCH-1:0]                        fifo_empty,
  output logic [N_BRANCH/2-1:0]                      overflow
);
  localparam int unsigned N_PHASE = N_BRANCH / 2;
  localparam int unsigned WORD_W  = 2 * SAMPLE_W;

  logic                         pk_valid;
  logic [N_BRANCH*SAMPLE_W-1:0] pk_words;

  phase_packer #(.SAMPLE_W(SAMPLE_W), .N_BRANCH(N_BRANCH)) u_packer (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_data (in_data),
    .pk_valid(pk_valid),
    .pk_words(pk_words)
  );

  for (genvar k = 0; k < N_PHASE; k++) begin : g_pair
    mirrored_fifo_pair #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .pk_valid(pk_valid),
      .pk_word (pk_words[k*WORD_W +: WORD_W]),
      .rd_ready(out_ready[k*COPIES +: COPIES]),
      .rd_valid(out_valid[k*COPIES +: COPIES]),
      .rd_data (out_data[k*COPIES*WORD_W +: COPIES*WORD_W]),
      .full    (fifo_full[k*COPIES +: COPIES]),
      .empty   (fifo_empty[k*COPIES +: COPIES]),
      .overflow(overflow[k])
    );
  end

  p_valid_not_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & fifo_empty) == '0);
endmodule

// File: tb/ssr_phase_repacker_bench.sv
module ssr_phase_repacker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 32;
  localparam int NB = 8;
  localparam int NP = 4;
  localparam int DEPTH = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [NB*SW-1:0] in_data;
  logic [NB-1:0]   out_ready;
  logic [NB-1:0]   out_valid;
  logic [NB*2*SW-1:0] out_data;
  logic [NB-1:0]   fifo_full, fifo_empty;
  logic [NP-1:0]   overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssr_phase_repacker #(.SAMPLE_W(SW), .N_BRANCH(NB), .FIFO_DEPTH(DEPTH)) u_ssr_phase_repacker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow)
  );

  function automatic logic [31:0] samp(int n, int b);
    return 32'hC000_0000 | (32'(n) << 8) | 32'(b);
  endfunction

  function automatic logic [63:0] word(int n, int k);
    return {samp(n, k + 4), samp(n, k)};
  endfunction

  function automatic logic [63:0] got(int c);
    return out_data[c*64 +: 64];
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '1; out_ready = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic push_vec(int n);
    @(negedge clk);
    in_valid = 1'b1;
    for (int b = 0; b < NB; b++) in_data[b*SW +: SW] = samp(n, b);
    @(posedge clk); #1;
    in_valid = 1'b0; in_data = {8{32'hDEAD_BEEF}};
  endtask

  task automatic idle(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); in_valid = 1'b0; in_data = {8{32'h5A5A_A5A5}};
      @(posedge clk); #1;
    end
  endtask

  task automatic pop_one(int c);
    @(negedge clk); out_ready[c] = 1'b1;
    @(posedge clk); #1; out_ready[c] = 1'b0;
  endtask

  task automatic drain_check(int c, int n0, int cnt, string req);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      check(out_valid[c], req, 64'(out_valid[c]), 64'd1);
      check(got(c) == word(n0 + i, c / 2), req, got(c), word(n0 + i, c / 2));
      out_ready[c] = 1'b1;
      @(posedge clk); #1; out_ready[c] = 1'b0;
    end
    @(negedge clk);
    check(fifo_empty[c] && !out_valid[c], req, 64'(fifo_empty[c]), 64'd1);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(out_valid == '0, "R1", 64'(out_valid), 64'd0);
    check(fifo_empty == 8'hFF, "R1", 64'(fifo_empty), 64'hFF);
    check(fifo_full == '0, "R1", 64'(fifo_full), 64'd0);
    check(overflow == '0, "R1", 64'(overflow), 64'd0);
  endtask

  // R2, R3: packing and latency
  task automatic t_pack_latency();
    do_reset();
    push_vec(5);
    @(negedge clk);
    check(out_valid == '0, "R3 early", 64'(out_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 8'hFF, "R3", 64'(out_valid), 64'hFF);
    for (int c = 0; c < NB; c++)
      check(got(c) == word(5, c / 2), "R2", got(c), word(5, c / 2));
    out_ready = 8'hFF;
    @(posedge clk); #1; out_ready = '0;
    @(negedge clk);
    check(fifo_empty == 8'hFF, "R2 drained", 64'(fifo_empty), 64'hFF);
  endtask

  // R4, R5, R6, R10: staggered independent consumers
  task automatic t_staggered();
    int idx [NB];
    bit stall [NB];
    logic [63:0] held [NB];
    logic [NB-1:0] rdy;
    do_reset();
    for (int n = 0; n < 12; n++) begin
      push_vec(n);
      if (n % 4 == 3) idle(1);
    end
    idle(2);
    for (int c = 0; c < NB; c++) begin idx[c] = 0; stall[c] = 0; held[c] = '0; end
    for (int t = 0; t < 120; t++) begin
      @(negedge clk);
      for (int c = 0; c < NB; c++) begin
        if (stall[c]) begin
          check(out_valid[c] && got(c) == held[c], "R10", got(c), held[c]);
        end
        rdy[c] = (t >= c * 7) && (((t + c) % 3) != 0);
        if (out_valid[c] && rdy[c]) begin
          check(got(c) == word(idx[c], c / 2), "R4", got(c), word(idx[c], c / 2));
          idx[c]++;
        end
        stall[c] = out_valid[c] && !rdy[c];
        held[c] = got(c);
      end
      out_ready = rdy;
      @(posedge clk); #1;
    end
    out_ready = '0;
    @(negedge clk);
    for (int c = 0; c < NB; c++)
      check(idx[c] == 12, "R5 R6 count", 64'(idx[c]), 64'd12);
    check(fifo_empty == 8'hFF, "R6", 64'(fifo_empty), 64'hFF);
  endtask

  // R7, R8, R9: full, paired skip, sticky overflow
  task automatic t_overflow();
    do_reset();
    for (int n = 0; n < DEPTH; n++) push_vec(n);
    idle(2);
    @(negedge clk);
    check(fifo_full == 8'hFF, "R7 full", 64'(fifo_full), 64'hFF);
    check(fifo_empty == '0, "R7 empty", 64'(fifo_empty), 64'd0);
    check(overflow == '0, "R7 no ovf", 64'(overflow), 64'd0);
    pop_one(1); pop_one(2); pop_one(3);
    push_vec(DEPTH);
    idle(2);
    @(negedge clk);
    check(overflow == 4'b1101, "R8 ovf", 64'(overflow), 64'hD);
    check(fifo_full[1] == 1'b0, "R8 odd copy skipped", 64'(fifo_full[1]), 64'd0);
    drain_check(1, 1, DEPTH - 1, "R8 pair0 odd");
    drain_check(0, 0, DEPTH, "R8 pair0 even");
    drain_check(2, 1, DEPTH, "R8 pair1 even");
    drain_check(3, 1, DEPTH, "R8 pair1 odd");
    push_vec(40);
    idle(2);
    @(negedge clk);
    check(overflow == 4'b1101, "R9", 64'(overflow), 64'hD);
    check(out_valid[0] && got(0) == word(40, 0), "R9 accepts", got(0), word(40, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pack_latency();
    t_staggered();
    t_overflow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule